// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an addressing request into a 20-bit physical byte address. An offset is first formed from the operands that the request supplies. The operands are a base register value, an index register value with a 2-bit scale, and two displacement constants. The block then adds that offset to a 16-bit segment value that has been moved up by four bit positions. The segment value comes from a small internal bank of four segment registers (code, stack, data, extra). The bank clears on reset and is loaded through a write port.

The generator is combinational from request to address. Only the segment bank holds state. Several segment:offset pairs can name the same physical byte, and no alignment rule is applied. An immediate-operand request produces no address and drops the valid flag. Upstream decode picks the mode and the segment. Downstream logic performs the memory access.

Top module: `seg_agu`

## Requirements
- R1: When `addr_valid` is 1, `phys_addr` equals (segment × 16 + `eff_offset`) modulo 2^20, so its low four bits always equal the low four bits of the offset.
- R2: Distinct segment:offset pairs that give the same sum produce the same physical address; segment 0x0000 with offset 0x0040 and segment 0x0004 with offset 0x0000 both give 0x00040.
- R3: Mode code 1 (direct) gives an offset of `disp_a + disp_b`. The two displacement fields are always summed before use, in every mode that takes a displacement.
- R4: Mode code 2 (register indirect) gives an offset equal to `base_val`; the index, scale and displacement inputs have no effect.
- R5: Mode code 3 (base plus displacement) gives an offset of `base_val + disp_a + disp_b`.
- R6: Mode code 4 (scaled index) gives an offset of `base_val + (index_val << scale) + disp_a + disp_b`, where scale code 00/01/10/11 means ×1/×2/×4/×8.
- R7: All offset arithmetic wraps modulo 2^16.
- R8: Mode code 0 (immediate) and the reserved codes 5 to 7 drive `addr_valid` to 0, with `eff_offset` and `phys_addr` at 0. Codes 1 to 4 drive `addr_valid` to 1.
- R9: `seg_sel` and `seg_wsel` use one code for both: 00 is the code segment, 01 the stack segment, 10 the data segment and 11 the extra segment.
- R10: Reset (synchronous, active high) clears all four segment registers to 0.
- R11: A segment write takes effect at the next rising clock edge. A request that uses the same segment in the write cycle sees the old value. Registers that are not written keep their values.
- R12: Any byte address is legal: odd and unaligned offsets still produce `addr_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_we | input | 1 | Segment bank write enable |
| seg_wsel | input | 2 | Segment register to write |
| seg_wdata | input | 16 | Value to write |
| mode | input | 3 | Addressing mode code |
| seg_sel | input | 2 | Segment used for this request |
| base_val | input | 16 | Base register value |
| index_val | input | 16 | Index register value |
| scale | input | 2 | Index scale code |
| disp_a | input | 16 | First displacement constant |
| disp_b | input | 16 | Second displacement constant |
| phys_addr | output | 20 | Physical byte address |
| eff_offset | output | 16 | Computed offset |
| addr_valid | output | 1 | An address was produced |

## Verification
Two activities can fall in the same cycle: loading a segment register and generating an address that reads that same register. The bench provokes this with a direct write. In that cycle it requests the data segment while writing the data segment, and expects the address built from the old value. On the next cycle it expects the new value. Random traffic then mixes writes to random registers with requests through random segments. A behavioural model updates its own segment array only after the clock edge, and the design is judged against that model on every cycle.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

    localparam int SEG_W     = 16;
    localparam int OFS_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PA_W      = SEG_W + SEG_SHIFT;
    localparam int NSEG      = 4;
    localparam int SSEL_W    = $clog2(NSEG);
    localparam int MODE_W    = 3;
    localparam int SCALE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM      = 3'd0,
        AM_DIRECT   = 3'd1,
        AM_INDIRECT = 3'd2,
        AM_BASE_DSP = 3'd3,
        AM_SCALED   = 3'd4,
        AM_RSV5     = 3'd5,
        AM_RSV6     = 3'd6,
        AM_RSV7     = 3'd7
    } addr_mode_e;

    typedef enum logic [SSEL_W-1:0] {
        SG_CODE  = 2'd0,
        SG_STACK = 2'd1,
        SG_DATA  = 2'd2,
        SG_EXTRA = 2'd3
    } seg_id_e;

    typedef struct packed {
        addr_mode_e          mode;
        logic [OFS_W-1:0]    base;
        logic [OFS_W-1:0]    index;
        logic [SCALE_W-1:0]  scale;
        logic [OFS_W-1:0]    disp;
    } ofs_req_t;

    typedef struct packed {
        logic [OFS_W-1:0] offset;
        logic             valid;
    } ofs_res_t;

    function automatic logic [OFS_W-1:0] scale_index(
        input logic [OFS_W-1:0]   idx,
        input logic [SCALE_W-1:0] sc
    );
        return idx << sc;
    endfunction

    function automatic logic [PA_W-1:0] seg_base(input logic [SEG_W-1:0] seg);
        return {seg, {SEG_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/seg_bank.sv
module seg_bank
    import seg_agu_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [SSEL_W-1:0]            wsel,
    input  logic [SEG_W-1:0]             wdata,
    input  logic [SSEL_W-1:0]            rsel,
    output logic [SEG_W-1:0]             rdata,
    output logic [NSEG-1:0][SEG_W-1:0]   file_q
);

    for (genvar g = 0; g < NSEG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                file_q[g] <= '0;
            end else if (we && (wsel == SSEL_W'(g))) begin
                file_q[g] <= wdata;
            end
        end
    end

    assign rdata = file_q[rsel];

endmodule

// File: rtl/seg_ofs_calc.sv
module seg_ofs_calc
    import seg_agu_pkg::*;
(
    input  ofs_req_t req,
    output ofs_res_t res
);

    logic [OFS_W-1:0] scaled_idx;

    always_comb begin
        scaled_idx = scale_index(req.index, req.scale);
        res        = '0;
        unique case (req.mode)
            AM_DIRECT: begin
                res.offset = req.disp;
                res.valid  = 1'b1;
            end
            AM_INDIRECT: begin
                res.offset = req.base;
                res.valid  = 1'b1;
            end
            AM_BASE_DSP: begin
                res.offset = req.base + req.disp;
                res.valid  = 1'b1;
            end
            AM_SCALED: begin
                res.offset = req.base + scaled_idx + req.disp;
                res.valid  = 1'b1;
            end
            default: begin
                res.offset = '0;
                res.valid  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/seg_phys_add.sv
module seg_phys_add
    import seg_agu_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    input  ofs_res_t         ofs,
    output logic [PA_W-1:0]  phys
);

    always_comb begin
        if (ofs.valid) begin
            phys = seg_base(seg) + PA_W'(ofs.offset);
        end else begin
            phys = '0;
        end
    end

endmodule

// File: rtl/seg_agu.sv
module seg_agu
    import seg_agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        seg_we,
    input  logic [1:0]  seg_wsel,
    input  logic [15:0] seg_wdata,
    input  logic [2:0]  mode,
    input  logic [1:0]  seg_sel,
    input  logic [15:0] base_val,
    input  logic [15:0] index_val,
    input  logic [1:0]  scale,
    input  logic [15:0] disp_a,
    input  logic [15:0] disp_b,
    output logic [19:0] phys_addr,
    output logic [15:0] eff_offset,
    output logic        addr_valid
);

    logic [NSEG-1:0][SEG_W-1:0] seg_file;
    logic [SEG_W-1:0]           seg_cur;
    ofs_req_t                   req;
    ofs_res_t                   res;

    always_comb begin
        req.mode  = addr_mode_e'(mode);
        req.base  = base_val;
        req.index = index_val;
        req.scale = scale;
        req.disp  = disp_a + disp_b;
    end

    seg_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (seg_we),
        .wsel   (seg_wsel),
        .wdata  (seg_wdata),
        .rsel   (seg_sel),
        .rdata  (seg_cur),
        .file_q (seg_file)
    );

    seg_ofs_calc u_ofs (
        .req (req),
        .res (res)
    );

    seg_phys_add u_phys (
        .seg  (seg_cur),
        .ofs  (res),
        .phys (phys_addr)
    );

    assign eff_offset = res.offset;
    assign addr_valid = res.valid;

endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk
    import seg_agu_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       seg_we,
    input logic [1:0]                 seg_wsel,
    input logic [15:0]                seg_wdata,
    input logic [2:0]                 mode,
    input logic [15:0]                base_val,
    input logic [19:0]                phys_addr,
    input logic [15:0]                eff_offset,
    input logic                       addr_valid,
    input logic [NSEG-1:0][SEG_W-1:0] seg_file
);

    AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> (phys_addr[3:0] == eff_offset[3:0])); // R1

    AST_INDIRECT_BASE: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2) |-> (eff_offset == base_val)); // R4

    AST_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 || mode > 3'd4) |-> (!addr_valid && phys_addr == '0)); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (seg_file == '0)); // R10

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        seg_we |=> (seg_file[$past(seg_wsel)] == $past(seg_wdata))); // R11

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !seg_we |=> $stable(seg_file)); // R11

endmodule

bind seg_agu seg_agu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .seg_we     (seg_we),
    .seg_wsel   (seg_wsel),
    .seg_wdata  (seg_wdata),
    .mode       (mode),
    .base_val   (base_val),
    .phys_addr  (phys_addr),
    .eff_offset (eff_offset),
    .addr_valid (addr_valid),
    .seg_file   (seg_file)
);

// File: tb/seg_agu_bench.sv
module seg_agu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        seg_we;
    logic [1:0]  seg_wsel;
    logic [15:0] seg_wdata;
    logic [2:0]  mode;
    logic [1:0]  seg_sel;
    logic [15:0] base_val;
    logic [15:0] index_val;
    logic [1:0]  scale;
    logic [15:0] disp_a;
    logic [15:0] disp_b;
    logic [19:0] phys_addr;
    logic [15:0] eff_offset;
    logic        addr_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int model_seg [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_agu u_seg_agu (
        .clk        (clk),
        .rst        (rst),
        .seg_we     (seg_we),
        .seg_wsel   (seg_wsel),
        .seg_wdata  (seg_wdata),
        .mode       (mode),
        .seg_sel    (seg_sel),
        .base_val   (base_val),
        .index_val  (index_val),
        .scale      (scale),
        .disp_a     (disp_a),
        .disp_b     (disp_b),
        .phys_addr  (phys_addr),
        .eff_offset (eff_offset),
        .addr_valid (addr_valid)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic step(
        input string tag,
        input bit we, input int wsel, input int wdata,
        input int m, input int sel, input int b, input int idx,
        input int sc, input int da, input int db
    );
        int ofs;
        int vld;
        int pa;
        seg_we = we; seg_wsel = 2'(wsel); seg_wdata = 16'(wdata);
        mode = 3'(m); seg_sel = 2'(sel); base_val = 16'(b);
        index_val = 16'(idx); scale = 2'(sc); disp_a = 16'(da); disp_b = 16'(db);
        vld = 1;
        case (m)
            1: ofs = da + db;
            2: ofs = b;
            3: ofs = b + da + db;
            4: ofs = b + idx * (1 << sc) + da + db;
            default: begin ofs = 0; vld = 0; end
        endcase
        ofs = ofs & 32'hFFFF;
        pa  = vld ? ((model_seg[sel] * 16 + ofs) & 32'hFFFFF) : 0;
        @(negedge clk);
        check(tag, "valid",  int'(addr_valid), vld);
        check(tag, "offset", int'(eff_offset), ofs);
        check(tag, "phys",   int'(phys_addr),  pa);
        @(posedge clk);
        if (we) model_seg[wsel] = wdata & 32'hFFFF;
        #1;
    endtask

    initial begin
        rst = 1'b1;
        seg_we = 0; seg_wsel = 0; seg_wdata = 0; mode = 0; seg_sel = 0;
        base_val = 0; index_val = 0; scale = 0; disp_a = 0; disp_b = 0;
        foreach (model_seg[i]) model_seg[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R10: reset leaves every segment at zero
        for (int s = 0; s < 4; s++) step("R10", 0, 0, 0, 1, s, 0, 0, 0, 16'h0040, 0);
        // R11 + R9: write data segment while reading it; old value is used
        step("R11", 1, 2, 16'h0004, 1, 2, 0, 0, 0, 0, 0);
        // R2: 0004:0000 and 0000:0040 alias
        step("R2", 0, 0, 0, 1, 2, 0, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 1, 0, 0, 0, 0, 16'h0040, 0);
        // R9: other segments untouched by the data segment write
        step("R9", 0, 0, 0, 1, 3, 0, 0, 0, 16'h0040, 0);
        // R1: physical wrap at 1 MB
        step("R1", 1, 1, 16'hFFFF, 1, 1, 0, 0, 0, 0, 0);
        step("R1", 0, 0, 0, 2, 1, 16'h0010, 0, 0, 0, 0);
        step("R1", 0, 0, 0, 2, 1, 16'h0023, 0, 0, 0, 0);
        // R7: offset wrap
        step("R7", 0, 0, 0, 3, 0, 16'hFFFF, 0, 0, 2, 0);
        step("R7", 0, 0, 0, 4, 0, 16'h8000, 16'h4000, 1, 16'hFFFF, 1);
        // R3: two displacements summed
        step("R3", 0, 0, 0, 1, 2, 16'h1234, 16'h55, 3, 20, 40);
        // R6: all scale codes
        for (int s = 0; s < 4; s++) step("R6", 0, 0, 0, 4, 2, 16'h0100, 3, s, 20, 40);
        // R4: displacements and index ignored
        step("R4", 0, 0, 0, 2, 2, 16'h0200, 16'h7777, 3, 16'h1111, 16'h2222);
        // R5
        step("R5", 0, 0, 0, 3, 3, 16'h0300, 16'h7777, 2, 16'h0010, 16'h0001);
        // R8: immediate and reserved codes
        for (int m = 0; m < 8; m++) if (m == 0 || m > 4) step("R8", 0, 0, 0, m, 2, 16'h0400, 1, 1, 5, 5);
        // R12: odd unaligned addresses are still valid
        step("R12", 0, 0, 0, 3, 2, 16'h0001, 0, 0, 16'h0002, 0);
        step("R12", 0, 0, 0, 4, 2, 16'h0003, 16'h0005, 2, 0, 0);

        // random traffic with concurrent writes
        for (int n = 0; n < 400; n++) begin
            int m;
            m = int'($urandom_range(0, 7));
            step(mode_tag(m), bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 65535)), m, int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 65535)),
                 int'($urandom_range(0, 65535)));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule